// File: doc/BRIEF.md
# Pipelined Synchronous Burst Static Memory

This block is a synthesizable model of a small synchronous static memory with a 32-bit word split into four byte lanes. Either of two strobes can open an access. The processor strobe always opens a read. The controller strobe opens a read or a write, depending on the write controls sampled on that same edge. Reads go through an address register and then a data-out register. Once an access is open, the advance input steps a four-beat burst through the low two address bits. A companion generator supplies the burst order, which is either linear or interleaved.

Writes cover either the whole word, through the global write input, or chosen lanes, through the byte-write enable and the per-lane strobes. The output drive flag tells the surrounding bus when the data-out register may be placed on the shared data wires.

Top module: `sync_burst_sram`

## Requirements
- R1: A cycle opened by the processor strobe (`pstb_n` low, `mce_n` low, `sce_p` high, `sce_n` low) is a read. It never writes the array, whatever `cstb_n`, `gw_n`, `bwe_n` and `bw_n` are doing on that edge.
- R2: The word at the address registered on a start edge appears on `dout`, with the valid state set, after the next rising edge. That is two register stages from address to data.
- R3: With `gw_n` low on a write edge, all four lanes are written from `din`, whatever `bw_n` holds.
- R4: With `gw_n` high, a write changes only the lanes whose `bw_n` bit is low (bit i controls `din[8i+7:8i]`), and only while `bwe_n` is low. With `bwe_n` high, the lane strobes write nothing.
- R5: The lane strobes and write controls are ignored on an edge that starts a processor cycle. No lane is written and the output drive is not suppressed.
- R6: On a continuing edge (both strobes high, an access open), a sampled write command writes the current burst address. It also forces `dout_en` low after that edge, even when `oe_n` is low.
- R7: A controller cycle starts only when `pstb_n` is high on the edge where `cstb_n` is low. The write controls on that edge choose write (to `addr`) or read.
- R8: A high `mce_n` blocks a processor cycle but does not block a controller cycle. The two secondary enables `sce_p` and `sce_n` gate both kinds of cycle.
- R9: A strobe edge that starts no cycle deselects the block. `dout_en` stays up for exactly one more cycle, then drops.
- R10: `dout_en` is high only when `oe_n` is low, the data-out register holds a valid read, and no write was sampled on the last edge. `oe_n` acts without a clock. After reset `dout_en` is low.
- R11: Each continuing edge with `adv_n` low advances the burst. With `linear` high, beat i uses low bits (start+i) mod 4. With `linear` low, beat i uses start XOR i. The upper address bits are held.
- R12: `adv_n` is ignored on a start edge. The first beat is always the registered start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr | input | AW (8) | Word address sampled on start edges |
| mce_n | input | 1 | Master enable, active low, gates processor cycles only |
| sce_p | input | 1 | Secondary enable, active high |
| sce_n | input | 1 | Secondary enable, active low |
| pstb_n | input | 1 | Processor cycle strobe, active low |
| cstb_n | input | 1 | Controller cycle strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 4 | Per-lane write strobes, active low |
| oe_n | input | 1 | Output enable, active low, unclocked |
| linear | input | 1 | Burst order select: 1 linear, 0 interleaved |
| din | input | 32 | Write data |
| dout | output | 32 | Data-out register |
| dout_en | output | 1 | Drive flag for the data bus |

## Verification
A read opened on edge k is sampled at the falling edge after edge k+1. Each burst beat follows one edge later, and the checks wait exactly that many falling edges. A write reaches the array on its own edge. Its effect is therefore checked through a later read, while the drive suppression it causes is checked at the falling edge right after the write edge. Deselect is checked twice: at the falling edge right after the deselect edge, where drive must still be up, and one falling edge later, where it must be down. The effect of `oe_n` is checked one time unit after it changes, with no clock edge in between.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
    localparam int LANE_W  = 8;
    localparam int N_LANES = 4;
    localparam int BEAT_W  = 2;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_PROC  = 2'd1,
        CYC_CTRL  = 2'd2,
        CYC_DESEL = 2'd3
    } cyc_e;
endpackage

// File: rtl/sbs_burst_seq.sv
module sbs_burst_seq #(
    parameter int AW = 8,
    parameter int CW = 2
) (
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] beat,
    input  logic          linear,
    output logic [AW-1:0] cur
);
    logic [CW-1:0] low;

    always_comb begin
        if (linear) low = base[CW-1:0] + beat;
        else        low = base[CW-1:0] ^ beat;
        cur = {base[AW-1:CW], low};
    end
endmodule

// File: rtl/sbs_byte_array.sv
module sbs_byte_array #(
    parameter int AW    = 8,
    parameter int LANES = 4,
    parameter int LW    = 8
) (
    input  logic                clk,
    input  logic [LANES-1:0]    we,
    input  logic [AW-1:0]       waddr,
    input  logic [LANES*LW-1:0] wdata,
    input  logic [AW-1:0]       raddr,
    output logic [LANES*LW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LW-1:0] mem_q [DEPTH];

        always_ff @(posedge clk) begin
            if (we[l]) mem_q[waddr] <= wdata[l*LW +: LW];
        end

        assign rdata[l*LW +: LW] = mem_q[raddr];
    end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
    parameter int AW    = 8,
    parameter int LANES = sbs_pkg::N_LANES,
    parameter int LW    = sbs_pkg::LANE_W,
    parameter int CW    = sbs_pkg::BEAT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       addr,
    input  logic                mce_n,
    input  logic                sce_p,
    input  logic                sce_n,
    input  logic                pstb_n,
    input  logic                cstb_n,
    input  logic                adv_n,
    input  logic                gw_n,
    input  logic                bwe_n,
    input  logic [LANES-1:0]    bw_n,
    input  logic                oe_n,
    input  logic                linear,
    input  logic [LANES*LW-1:0] din,
    output logic [LANES*LW-1:0] dout,
    output logic                dout_en
);
    import sbs_pkg::*;

    localparam int DW = LANES * LW;

    typedef struct packed {
        logic          act;
        logic          rd;
        logic [AW-1:0] base;
        logic [CW-1:0] beat;
        logic          vld;
        logic          wblk;
        logic [DW-1:0] dout;
    } st_t;

    st_t st_d, st_q;
    cyc_e cyc;

    logic [AW-1:0]    cur_addr;
    logic [AW-1:0]    mem_waddr;
    logic [LANES-1:0] mem_we;
    logic [LANES-1:0] lanes;
    logic [DW-1:0]    rd_word;
    logic             wr_cmd;

    sbs_burst_seq #(.AW(AW), .CW(CW)) u_seq (
        .base   (st_q.base),
        .beat   (st_q.beat),
        .linear (linear),
        .cur    (cur_addr)
    );

    sbs_byte_array #(.AW(AW), .LANES(LANES), .LW(LW)) u_arr (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (din),
        .raddr (cur_addr),
        .rdata (rd_word)
    );

    always_comb begin
        logic chips_on;
        chips_on = sce_p & ~sce_n;
        if (~pstb_n & ~mce_n & chips_on)      cyc = CYC_PROC;
        else if (~cstb_n & pstb_n & chips_on) cyc = CYC_CTRL;
        else if (~pstb_n | ~cstb_n)           cyc = CYC_DESEL;
        else                                  cyc = CYC_IDLE;

        if (~gw_n)       lanes = {LANES{1'b1}};
        else if (~bwe_n) lanes = ~bw_n;
        else             lanes = '0;
        wr_cmd = |lanes;

        st_d      = st_q;
        mem_we    = '0;
        mem_waddr = cur_addr;
        st_d.dout = rd_word;
        st_d.vld  = st_q.act & st_q.rd;
        st_d.wblk = wr_cmd & (cyc != CYC_PROC);

        case (cyc)
            CYC_PROC: begin
                st_d.act  = 1'b1;
                st_d.rd   = 1'b1;
                st_d.base = addr;
                st_d.beat = '0;
            end
            CYC_CTRL: begin
                st_d.act  = 1'b1;
                st_d.rd   = ~wr_cmd;
                st_d.base = addr;
                st_d.beat = '0;
                mem_we    = lanes;
                mem_waddr = addr;
            end
            CYC_DESEL: begin
                st_d.act = 1'b0;
                st_d.rd  = 1'b0;
            end
            default: begin
                if (st_q.act) begin
                    if (wr_cmd) begin
                        mem_we  = lanes;
                        st_d.rd = 1'b0;
                    end
                    if (~adv_n) st_d.beat = st_q.beat + CW'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout    = st_q.dout;
    assign dout_en = ~oe_n & st_q.vld & ~st_q.wblk;
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pstb_n,
    input logic             cstb_n,
    input logic             mce_n,
    input logic             sce_p,
    input logic             sce_n,
    input logic             gw_n,
    input logic             bwe_n,
    input logic [LANES-1:0] bw_n,
    input logic             oe_n,
    input logic             dout_en,
    input logic             act_q,
    input logic             vld_q,
    input logic [LANES-1:0] mem_we
);
    logic p_go, c_go;
    assign p_go = !pstb_n && !mce_n && sce_p && !sce_n;
    assign c_go = !cstb_n && pstb_n && sce_p && !sce_n;

    AST_PROC_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        p_go |-> mem_we == '0); // R1
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        p_go |=> ##1 vld_q); // R2
    AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (c_go && !gw_n) |-> mem_we == {LANES{1'b1}}); // R3
    AST_NO_LANE_WITHOUT_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (gw_n && bwe_n) |-> mem_we == '0); // R4
    AST_WRITE_BLOCKS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bwe_n && bw_n != {LANES{1'b1}} && !p_go) |=> !dout_en); // R6
    AST_MASTER_SPARES_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (c_go && mce_n) |=> act_q); // R8
    AST_SINGLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        ((!pstb_n || !cstb_n) && !p_go && !c_go) |=> !act_q ##1 !vld_q); // R9
    AST_DRIVE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> (!oe_n && vld_q)); // R10
endmodule

bind sync_burst_sram sbs_checker #(.LANES(LANES)) u_sbs_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pstb_n  (pstb_n),
    .cstb_n  (cstb_n),
    .mce_n   (mce_n),
    .sce_p   (sce_p),
    .sce_n   (sce_n),
    .gw_n    (gw_n),
    .bwe_n   (bwe_n),
    .bw_n    (bw_n),
    .oe_n    (oe_n),
    .dout_en (dout_en),
    .act_q   (st_q.act),
    .vld_q   (st_q.vld),
    .mem_we  (mem_we)
);

// File: tb/test_sync_burst_sram.sv
module test_sync_burst_sram;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        mce_n = 1'b0, sce_p = 1'b1, sce_n = 1'b0;
    logic        pstb_n = 1'b1, cstb_n = 1'b1, adv_n = 1'b1;
    logic        gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0, linear = 1'b0;
    logic [3:0]  bw_n = 4'hF;
    logic [31:0] din = '0;
    logic [31:0] dout;
    logic        dout_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] exp_mem [256];

    always #10 clk = ~clk;

    sync_burst_sram i_sync_burst_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .mce_n(mce_n), .sce_p(sce_p),
        .sce_n(sce_n), .pstb_n(pstb_n), .cstb_n(cstb_n), .adv_n(adv_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .linear(linear),
        .din(din), .dout(dout), .dout_en(dout_en)
    );

    function automatic logic [31:0] pat(input int a);
        return (32'(a) * 32'h0347_1A2D) ^ 32'hA5C3_0F69;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        pstb_n = 1'b1; cstb_n = 1'b1; adv_n = 1'b1; gw_n = 1'b1; bwe_n = 1'b1;
        bw_n = 4'hF; oe_n = 1'b0; mce_n = 1'b0; sce_p = 1'b1; sce_n = 1'b0;
    endtask

    task automatic wr(input int a, input logic [31:0] d, input logic g, input logic be,
                      input logic [3:0] bw);
        @(negedge clk);
        cstb_n = 1'b0; addr = 8'(a); din = d; gw_n = g; bwe_n = be; bw_n = bw;
        @(negedge clk);
        idle();
    endtask

    task automatic rd_chk(input int a, input string req);
        @(negedge clk);
        pstb_n = 1'b0; addr = 8'(a);
        @(negedge clk);
        pstb_n = 1'b1;
        @(negedge clk);
        chk({req, " drive"}, 32'(dout_en), 32'd1);
        chk({req, " data"}, dout, exp_mem[a]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        chk("R10 reset drive", 32'(dout_en), 32'd0);
        rst_n = 1'b1;

        // R3: global writes over the whole array, R2 reads back
        for (int a = 0; a < 256; a++) begin
            wr(a, pat(a), 1'b0, 1'b1, 4'b0101);
            exp_mem[a] = pat(a);
        end
        for (int a = 0; a < 256; a++) rd_chk(a, "R2 R3 global");

        // R4: every lane mask
        for (int m = 0; m < 16; m++) begin
            logic [31:0] nd;
            nd = ~pat(m + 300);
            wr(m, nd, 1'b1, 1'b0, ~4'(m));
            for (int l = 0; l < 4; l++)
                if (m[l]) exp_mem[m][l*8 +: 8] = nd[l*8 +: 8];
            rd_chk(m, "R4 lanes");
        end
        wr(20, 32'hDEAD_BEEF, 1'b1, 1'b1, 4'h0);
        rd_chk(20, "R4 bwe high");

        // R1 R5: processor start with write controls asserted
        @(negedge clk);
        pstb_n = 1'b0; cstb_n = 1'b0; gw_n = 1'b0; bwe_n = 1'b0; bw_n = 4'h0;
        addr = 8'd30; din = 32'h1111_2222;
        @(negedge clk);
        idle();
        @(negedge clk);
        chk("R5 not blocked", 32'(dout_en), 32'd1);
        chk("R1 read data", dout, exp_mem[30]);
        rd_chk(30, "R1 no write");

        // R7: controller strobe with processor strobe low does not start
        @(negedge clk);
        mce_n = 1'b1; pstb_n = 1'b0; cstb_n = 1'b0; gw_n = 1'b0; addr = 8'd40;
        din = 32'h3333_4444;
        @(negedge clk);
        idle();
        rd_chk(40, "R7 no start");

        // R8: master enable high, controller write still works
        @(negedge clk);
        mce_n = 1'b1; cstb_n = 1'b0; gw_n = 1'b0; addr = 8'd41; din = 32'h5555_6666;
        @(negedge clk);
        idle();
        exp_mem[41] = 32'h5555_6666;
        rd_chk(41, "R8 ctrl write");

        // R9: single-cycle deselect
        rd_chk(60, "R9 pre");
        pstb_n = 1'b0; sce_p = 1'b0;
        @(negedge clk);
        idle();
        chk("R9 one more cycle", 32'(dout_en), 32'd1);
        @(negedge clk);
        chk("R9 off", 32'(dout_en), 32'd0);

        // R8: master enable blocks the processor strobe
        @(negedge clk);
        mce_n = 1'b1; pstb_n = 1'b0; addr = 8'd50;
        @(negedge clk);
        idle();
        @(negedge clk);
        chk("R8 proc blocked", 32'(dout_en), 32'd0);

        // R10: output enable without a clock
        rd_chk(70, "R10 pre");
        #1 oe_n = 1'b1;
        #1 chk("R10 oe high", 32'(dout_en), 32'd0);
        oe_n = 1'b0;
        #1 chk("R10 oe low", 32'(dout_en), 32'd1);

        // R6: write on a continuing edge blocks drive and writes current address
        rd_chk(80, "R6 pre");
        bwe_n = 1'b0; bw_n = 4'b1110; din = 32'h0000_00C7;
        @(negedge clk);
        idle();
        chk("R6 drive off", 32'(dout_en), 32'd0);
        exp_mem[80][7:0] = 8'hC7;
        rd_chk(80, "R6 written");

        // R11 R12: bursts in both orders from every start offset
        for (int md = 0; md < 2; md++) begin
            for (int lo = 0; lo < 4; lo++) begin
                int b;
                b = 100 + lo;
                @(negedge clk);
                linear = md[0]; pstb_n = 1'b0; addr = 8'(b); adv_n = 1'b0;
                @(negedge clk);
                pstb_n = 1'b1;
                for (int i = 0; i < 4; i++) begin
                    int e;
                    @(negedge clk);
                    e = (b & 8'hFC) | (md ? ((lo + i) & 3) : (lo ^ i));
                    chk(i == 0 ? "R12 first beat" : "R11 burst beat", dout, exp_mem[e]);
                end
                adv_n = 1'b1;
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule